// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of an 8-bit accumulator-style processor core. It holds no state. It decodes its operation straight from the 14-bit instruction word, and it always takes the working register as its first operand. The second operand comes from a multiplexer. That multiplexer picks the data-RAM read bus, the special-function-register read bus, or the 8-bit literal in the instruction. The block returns an 8-bit result and three flag values: zero, carry and digit carry. Each flag has its own load strobe. The block also raises one destination request, either load-W or load-file. The surrounding core does the actual writes and holds the stored carry, which comes back in on `carry_in`.

A controller drives `instr` from its instruction register and `sfr_sel` from its address decode. It then uses the strobes to update W, the addressed file register and the status bits. Since the block is purely combinational, every output follows its inputs within the same cycle.

Top module: `acc_alu`

## Requirements
- R1: The second operand is `ram_data` when `sfr_sel` is 0 and `sfr_data` when `sfr_sel` is 1. For literal-class instructions (`instr[13:12]`=11) it is `instr[7:0]`, whatever `sfr_sel` is.
- R2: Add (byte-class opcode `instr[11:8]`=0111; literal-class `instr[11:8]`=111x) gives (B+W) mod 256. It loads C with the carry out of bit 7, DC with the carry out of bit 3, and Z.
- R3: Subtract (byte opcode 0010; literal 110x) gives (B−W) mod 256. It loads C=1 when there is no borrow (B≥W), DC=1 when there is no borrow out of the low nibble, and Z.
- R4: The logical operations load only Z. OR is byte opcode 0100 or literal 1000. AND is byte opcode 0101 or literal 1001. XOR is byte opcode 0110 or literal 1010.
- R5: The byte opcodes below update Z only:
  - 0001 gives 0 (clear).
  - 0011 gives B−1.
  - 1000 gives B (move).
  - 1001 gives ~B.
  - 1010 gives B+1.
- R6: Rotate right (byte opcode 1100) gives {carry_in, B[7:1]} with C=B[0]. Rotate left (byte opcode 1101) gives {B[6:0], carry_in} with C=B[7]. Both load C only, never Z or DC.
- R7: In the bit class (`instr[13:12]`=01), `instr[11:10]`=00 clears bit `instr[9:7]` of B and =01 sets it. Both request load-file, and no flag loads.
- R8: For byte-class instructions, destination bit `instr[7]`=0 requests load-W and 1 requests load-file. Literal-class instructions request load-W. The two requests are never active together.
- R9: These instructions raise no load and no flag strobe:
  - the control class (`instr[13:12]`=10);
  - the bit-test forms (`instr[11:10]`=1x);
  - byte opcode 0000 with `instr[7]`=0;
  - literal `instr[11:8]`=1011.
- R10: Byte opcodes that change B without touching flags request a write and raise no flag strobe:
  - 0000 with `instr[7]`=1 stores W;
  - 1011 gives B−1;
  - 1110 gives the nibble swap;
  - 1111 gives B+1.

  Literal `instr[11:8]`=0xxx loads the literal into W.
- R11: `zero_out` is 1 exactly when `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 14 | Instruction word currently executing |
| w_data | input | 8 | Working register, operand one |
| ram_data | input | 8 | Data-RAM read value |
| sfr_data | input | 8 | Special-function-register read value |
| sfr_sel | input | 1 | 1 selects `sfr_data` as the file operand |
| carry_in | input | 1 | Stored carry bit |
| result | output | 8 | Operation result |
| zero_out | output | 1 | Zero flag value |
| carry_out | output | 1 | Carry flag value, valid with `carry_ld` |
| dcarry_out | output | 1 | Digit-carry flag value, valid with `dcarry_ld` |
| zero_ld | output | 1 | Load strobe for Z |
| carry_ld | output | 1 | Load strobe for C |
| dcarry_ld | output | 1 | Load strobe for DC |
| w_ld | output | 1 | Request to write `result` to W |
| file_ld | output | 1 | Request to write `result` to the file register |

## Verification
On every evaluation the checker enforces the structural rules:
- The two destination requests never coincide.
- Literal and control instructions never write the file register.
- The bit-modify, bit-test and control classes never strobe a flag.
- Rotates strobe carry alone.
- The zero output agrees with the result.

Only the bench's reference model can show that the values are right: sums, differences, borrow polarity on carry and digit carry, carry rotating through the result, the chosen bit position, and the operand that the multiplexer picked.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW   = 8;
  localparam int IW   = 14;
  localparam int NIB  = DW / 2;
  localparam int BIW  = $clog2(DW);

  typedef enum logic [3:0] {
    OP_PASS_W, OP_PASS_B, OP_ZERO, OP_ADD,
    OP_SUB,    OP_INC,    OP_DEC,  OP_OR,
    OP_AND,    OP_XOR,    OP_COM,  OP_RR,
    OP_RL,     OP_SWAP,   OP_BCLR, OP_BSET
  } alu_op_e;

  typedef struct packed {
    alu_op_e        op;
    logic           use_imm;
    logic           wr_w;
    logic           wr_f;
    logic           upd_z;
    logic           upd_c;
    logic           upd_dc;
    logic [BIW-1:0] bit_idx;
  } alu_ctrl_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [IW-1:0] instr,
  output alu_ctrl_t     ctrl
);
  logic [1:0] cls;
  logic [3:0] opc;
  logic       dst;

  assign cls = instr[IW-1:IW-2];
  assign opc = instr[11:8];
  assign dst = instr[7];

  always_comb begin
    ctrl         = '0;
    ctrl.op      = OP_PASS_W;
    ctrl.bit_idx = instr[7+BIW-1:7];
    unique case (cls)
      2'b00: begin
        ctrl.wr_w = !dst;
        ctrl.wr_f = dst;
        unique case (opc)
          4'h0: begin ctrl.op = OP_PASS_W; ctrl.wr_w = 1'b0; end
          4'h1: begin ctrl.op = OP_ZERO; ctrl.upd_z = 1'b1; end
          4'h2: begin ctrl.op = OP_SUB;  ctrl.upd_z = 1'b1; ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; end
          4'h3: begin ctrl.op = OP_DEC;  ctrl.upd_z = 1'b1; end
          4'h4: begin ctrl.op = OP_OR;   ctrl.upd_z = 1'b1; end
          4'h5: begin ctrl.op = OP_AND;  ctrl.upd_z = 1'b1; end
          4'h6: begin ctrl.op = OP_XOR;  ctrl.upd_z = 1'b1; end
          4'h7: begin ctrl.op = OP_ADD;  ctrl.upd_z = 1'b1; ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; end
          4'h8: begin ctrl.op = OP_PASS_B; ctrl.upd_z = 1'b1; end
          4'h9: begin ctrl.op = OP_COM;  ctrl.upd_z = 1'b1; end
          4'hA: begin ctrl.op = OP_INC;  ctrl.upd_z = 1'b1; end
          4'hB: ctrl.op = OP_DEC;
          4'hC: begin ctrl.op = OP_RR;   ctrl.upd_c = 1'b1; end
          4'hD: begin ctrl.op = OP_RL;   ctrl.upd_c = 1'b1; end
          4'hE: ctrl.op = OP_SWAP;
          default: ctrl.op = OP_INC;
        endcase
      end
      2'b01: begin
        if (!instr[11]) begin
          ctrl.op   = instr[10] ? OP_BSET : OP_BCLR;
          ctrl.wr_f = 1'b1;
        end
      end
      2'b10: ctrl.op = OP_PASS_W;
      default: begin
        ctrl.use_imm = 1'b1;
        ctrl.wr_w    = 1'b1;
        casez (opc)
          4'b0???: ctrl.op = OP_PASS_B;
          4'b1000: begin ctrl.op = OP_OR;  ctrl.upd_z = 1'b1; end
          4'b1001: begin ctrl.op = OP_AND; ctrl.upd_z = 1'b1; end
          4'b1010: begin ctrl.op = OP_XOR; ctrl.upd_z = 1'b1; end
          4'b1011: begin ctrl.op = OP_PASS_W; ctrl.wr_w = 1'b0; end
          4'b110?: begin ctrl.op = OP_SUB; ctrl.upd_z = 1'b1; ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; end
          default: begin ctrl.op = OP_ADD; ctrl.upd_z = 1'b1; ctrl.upd_c = 1'b1; ctrl.upd_dc = 1'b1; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/acc_alu_opnd.sv
module acc_alu_opnd
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] ram_data,
  input  logic [DW-1:0] sfr_data,
  input  logic [DW-1:0] imm,
  input  logic          sfr_sel,
  input  logic          use_imm,
  output logic [DW-1:0] opnd_b
);
  always_comb begin
    if (use_imm)      opnd_b = imm;
    else if (sfr_sel) opnd_b = sfr_data;
    else              opnd_b = ram_data;
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  a_w,
  input  logic [DW-1:0]  b_f,
  input  logic           cin,
  input  logic [BIW-1:0] bit_idx,
  output logic [DW-1:0]  res,
  output logic           cy,
  output logic           dcy
);
  logic [DW-1:0]  add_y;
  logic           add_ci;
  logic [DW:0]    add_sum;
  logic [NIB:0]   nib_sum;
  logic [DW-1:0]  mask;

  always_comb begin
    add_y  = '0;
    add_ci = 1'b0;
    unique case (op)
      OP_ADD:  begin add_y = a_w;   add_ci = 1'b0; end
      OP_SUB:  begin add_y = ~a_w;  add_ci = 1'b1; end
      OP_INC:  begin add_y = '0;    add_ci = 1'b1; end
      OP_DEC:  begin add_y = '1;    add_ci = 1'b0; end
      default: begin add_y = '0;    add_ci = 1'b0; end
    endcase
  end

  assign add_sum = {1'b0, b_f} + {1'b0, add_y} + {{DW{1'b0}}, add_ci};
  assign nib_sum = {1'b0, b_f[NIB-1:0]} + {1'b0, add_y[NIB-1:0]} + {{NIB{1'b0}}, add_ci};

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (bit_idx == BIW'(i));
  end

  always_comb begin
    res = a_w;
    cy  = add_sum[DW];
    dcy = nib_sum[NIB];
    unique case (op)
      OP_PASS_W: res = a_w;
      OP_PASS_B: res = b_f;
      OP_ZERO:   res = '0;
      OP_ADD, OP_SUB, OP_INC, OP_DEC: res = add_sum[DW-1:0];
      OP_OR:     res = a_w | b_f;
      OP_AND:    res = a_w & b_f;
      OP_XOR:    res = a_w ^ b_f;
      OP_COM:    res = ~b_f;
      OP_RR:     begin res = {cin, b_f[DW-1:1]}; cy = b_f[0]; end
      OP_RL:     begin res = {b_f[DW-2:0], cin}; cy = b_f[DW-1]; end
      OP_SWAP:   res = {b_f[NIB-1:0], b_f[DW-1:NIB]};
      OP_BCLR:   res = b_f & ~mask;
      default:   res = b_f | mask;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [13:0] instr,
  input  logic [7:0]  w_data,
  input  logic [7:0]  ram_data,
  input  logic [7:0]  sfr_data,
  input  logic        sfr_sel,
  input  logic        carry_in,
  output logic [7:0]  result,
  output logic        zero_out,
  output logic        carry_out,
  output logic        dcarry_out,
  output logic        zero_ld,
  output logic        carry_ld,
  output logic        dcarry_ld,
  output logic        w_ld,
  output logic        file_ld
);
  alu_ctrl_t     ctrl;
  logic [DW-1:0] opnd_b;

  acc_alu_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  acc_alu_opnd u_mux (
    .ram_data (ram_data),
    .sfr_data (sfr_data),
    .imm      (instr[DW-1:0]),
    .sfr_sel  (sfr_sel),
    .use_imm  (ctrl.use_imm),
    .opnd_b   (opnd_b)
  );

  acc_alu_core u_core (
    .op      (ctrl.op),
    .a_w     (w_data),
    .b_f     (opnd_b),
    .cin     (carry_in),
    .bit_idx (ctrl.bit_idx),
    .res     (result),
    .cy      (carry_out),
    .dcy     (dcarry_out)
  );

  assign zero_out  = (result == '0);
  assign zero_ld   = ctrl.upd_z;
  assign carry_ld  = ctrl.upd_c;
  assign dcarry_ld = ctrl.upd_dc;
  assign w_ld      = ctrl.wr_w;
  assign file_ld   = ctrl.wr_f;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic [13:0] instr,
  input logic [7:0]  result,
  input logic        zero_out,
  input logic        zero_ld,
  input logic        carry_ld,
  input logic        dcarry_ld,
  input logic        w_ld,
  input logic        file_ld
);
  always_comb begin
    // R8: at most one destination request
    assert_one_dest_R8: assert ($onehot0({w_ld, file_ld}))
      else $error("two destination requests");
    // R8: literal class never targets the file register
    assert_lit_to_w_R8: assert (!(instr[13:12] == 2'b11 && file_ld))
      else $error("literal wrote file");
    // R7 / R9: bit class never strobes a flag
    assert_bit_noflag_R7: assert (!(instr[13:12] == 2'b01 && (zero_ld || carry_ld || dcarry_ld)))
      else $error("bit op strobed a flag");
    // R9: control class is silent
    assert_ctrl_quiet_R9: assert (!(instr[13:12] == 2'b10 &&
                                    (zero_ld || carry_ld || dcarry_ld || w_ld || file_ld)))
      else $error("control class raised a strobe");
    // R6: rotates strobe carry only
    assert_rot_conly_R6: assert (!(instr[13:12] == 2'b00 && instr[11:9] == 3'b110 &&
                                   !(carry_ld && !zero_ld && !dcarry_ld)))
      else $error("rotate strobes wrong");
    // R11: zero value tracks the result
    assert_zero_val_R11: assert (zero_out == (result == 8'h00))
      else $error("zero flag mismatch");
  end
endmodule

bind acc_alu acc_alu_chk u_chk (
  .instr     (instr),
  .result    (result),
  .zero_out  (zero_out),
  .zero_ld   (zero_ld),
  .carry_ld  (carry_ld),
  .dcarry_ld (dcarry_ld),
  .w_ld      (w_ld),
  .file_ld   (file_ld)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  w_data = '0, ram_data = '0, sfr_data = '0;
  logic        sfr_sel = 1'b0, carry_in = 1'b0;
  logic [7:0]  result;
  logic        zero_out, carry_out, dcarry_out;
  logic        zero_ld, carry_ld, dcarry_ld, w_ld, file_ld;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .instr(instr), .w_data(w_data), .ram_data(ram_data), .sfr_data(sfr_data),
    .sfr_sel(sfr_sel), .carry_in(carry_in), .result(result), .zero_out(zero_out),
    .carry_out(carry_out), .dcarry_out(dcarry_out), .zero_ld(zero_ld),
    .carry_ld(carry_ld), .dcarry_ld(dcarry_ld), .w_ld(w_ld), .file_ld(file_ld)
  );

  // Behavioural reference: integers only
  int e_res, e_c, e_dc, e_lz, e_lc, e_ldc, e_lw, e_lf;
  string e_req;

  task automatic model();
    int cls = instr[13:12];
    int opc = instr[11:8];
    int d   = instr[7];
    int w   = w_data;
    int b   = (cls == 3) ? int'(instr[7:0]) : (sfr_sel ? int'(sfr_data) : int'(ram_data));
    e_res = w; e_c = 0; e_dc = 0; e_lz = 0; e_lc = 0; e_ldc = 0; e_lw = 0; e_lf = 0;
    e_req = "R9";
    if (cls == 0) begin
      e_lw = (d == 0); e_lf = (d == 1);
      case (opc)
        0:  begin e_res = w; e_lw = 0; e_req = d ? "R10" : "R9"; end
        1:  begin e_res = 0; e_lz = 1; e_req = "R5"; end
        2:  begin e_res = (b - w) & 255; e_c = (b >= w); e_dc = ((b & 15) >= (w & 15));
                  e_lz = 1; e_lc = 1; e_ldc = 1; e_req = "R3"; end
        3:  begin e_res = (b + 255) & 255; e_lz = 1; e_req = "R5"; end
        4:  begin e_res = w | b; e_lz = 1; e_req = "R4"; end
        5:  begin e_res = w & b; e_lz = 1; e_req = "R4"; end
        6:  begin e_res = w ^ b; e_lz = 1; e_req = "R4"; end
        7:  begin e_res = (b + w) & 255; e_c = (b + w) > 255; e_dc = ((b & 15) + (w & 15)) > 15;
                  e_lz = 1; e_lc = 1; e_ldc = 1; e_req = "R2"; end
        8:  begin e_res = b; e_lz = 1; e_req = "R5"; end
        9:  begin e_res = 255 - b; e_lz = 1; e_req = "R5"; end
        10: begin e_res = (b + 1) & 255; e_lz = 1; e_req = "R5"; end
        11: begin e_res = (b + 255) & 255; e_req = "R10"; end
        12: begin e_res = (carry_in * 128) + (b / 2); e_c = b % 2; e_lc = 1; e_req = "R6"; end
        13: begin e_res = ((b * 2) & 255) + carry_in; e_c = b / 128; e_lc = 1; e_req = "R6"; end
        14: begin e_res = ((b % 16) * 16) + (b / 16); e_req = "R10"; end
        default: begin e_res = (b + 1) & 255; e_req = "R10"; end
      endcase
    end else if (cls == 1) begin
      int k = instr[9:7];
      int p = 1 << k;
      if (opc < 4)      begin e_res = b & ~p & 255; e_lf = 1; e_req = "R7"; end
      else if (opc < 8) begin e_res = b | p;        e_lf = 1; e_req = "R7"; end
    end else if (cls == 3) begin
      e_lw = 1;
      if (opc < 8)        begin e_res = b; e_req = "R10"; end
      else if (opc == 8)  begin e_res = w | b; e_lz = 1; e_req = "R4"; end
      else if (opc == 9)  begin e_res = w & b; e_lz = 1; e_req = "R4"; end
      else if (opc == 10) begin e_res = w ^ b; e_lz = 1; e_req = "R4"; end
      else if (opc == 11) begin e_lw = 0; e_req = "R9"; end
      else if (opc < 14)  begin e_res = (b - w) & 255; e_c = (b >= w); e_dc = ((b & 15) >= (w & 15));
                                e_lz = 1; e_lc = 1; e_ldc = 1; e_req = "R3"; end
      else                begin e_res = (b + w) & 255; e_c = (b + w) > 255; e_dc = ((b & 15) + (w & 15)) > 15;
                                e_lz = 1; e_lc = 1; e_ldc = 1; e_req = "R2"; end
    end
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    model();
    if ({zero_ld, carry_ld, dcarry_ld, w_ld, file_ld} !=
        {e_lz[0], e_lc[0], e_ldc[0], e_lw[0], e_lf[0]}) bad = 1;
    if ((e_lw || e_lf) && result != e_res[7:0]) bad = 1;
    if (zero_out != (result == 8'h00)) bad = 1;           // R11
    if (e_lz && zero_out != (e_res == 0)) bad = 1;
    if (e_lc && carry_out != e_c[0]) bad = 1;
    if (e_ldc && dcarry_out != e_dc[0]) bad = 1;
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s/%s instr=%h w=%h b_sel=%0d: got res=%h z=%b c=%b dc=%b ld=%b%b%b%b%b exp res=%h c=%0d dc=%0d ld=%0d%0d%0d%0d%0d",
               e_req, tag, instr, w_data, sfr_sel, result, zero_out, carry_out, dcarry_out,
               zero_ld, carry_ld, dcarry_ld, w_ld, file_ld, e_res[7:0], e_c, e_dc,
               e_lz, e_lc, e_ldc, e_lw, e_lf);
    end
  endtask

  task automatic apply(input logic [13:0] i, input logic [7:0] w, input logic [7:0] r,
                       input logic [7:0] s, input logic sel, input logic c, input string tag);
    @(posedge clk);
    #1;
    instr = i; w_data = w; ram_data = r; sfr_data = s; sfr_sel = sel; carry_in = c;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("reset_R9");          // instr 0 during reset: no strobes
    rst_n = 1'b1;
    // R1: operand source
    apply(14'h0880, 8'h11, 8'h5A, 8'hA5, 1'b0, 1'b0, "R1_ram");
    apply(14'h0880, 8'h11, 8'h5A, 8'hA5, 1'b1, 1'b0, "R1_sfr");
    apply(14'h3042, 8'h11, 8'h5A, 8'hA5, 1'b1, 1'b0, "R1_imm");
    // R2: add, nibble and byte carry
    apply(14'h0705, 8'h0F, 8'h01, 8'h00, 1'b0, 1'b0, "R2_dc");
    apply(14'h0785, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, "R2_wrap");
    apply(14'h3E80, 8'h80, 8'h00, 8'h00, 1'b0, 1'b1, "R2_lit");
    // R3: subtract borrow polarity
    apply(14'h0205, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, "R3_borrow");
    apply(14'h0205, 8'h22, 8'h22, 8'h00, 1'b0, 1'b0, "R3_equal");
    apply(14'h3C10, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, "R3_lit_dc");
    // R4, R5
    apply(14'h0685, 8'h3C, 8'h3C, 8'h00, 1'b0, 1'b0, "R4_xor0");
    apply(14'h3900, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, "R4_andlit");
    apply(14'h0180, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0, "R5_clr");
    apply(14'h0A05, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, "R5_incwrap");
    // R6: rotate through carry
    apply(14'h0C85, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, "R6_rr");
    apply(14'h0D85, 8'h00, 8'h80, 8'h00, 1'b0, 1'b0, "R6_rl_zero");
    // R7: bit modify
    apply(14'h1385, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, "R7_clr7");
    apply(14'h1405, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R7_set0");
    // R8: destination
    apply(14'h0405, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b0, "R8_dst_w");
    apply(14'h0485, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b0, "R8_dst_f");
    // R9: silent forms
    apply(14'h2123, 8'h55, 8'h66, 8'h00, 1'b0, 1'b1, "R9_ctrl");
    apply(14'h1805, 8'h55, 8'h66, 8'h00, 1'b0, 1'b1, "R9_test");
    apply(14'h3B00, 8'h55, 8'h66, 8'h00, 1'b0, 1'b1, "R9_lit_rsv");
    // R10: writes without flags
    apply(14'h0E85, 8'h00, 8'hA5, 8'h00, 1'b0, 1'b0, "R10_swap");
    apply(14'h0B05, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, "R10_dec");
    apply(14'h0085, 8'h77, 8'h00, 8'h00, 1'b0, 1'b0, "R10_store");
    // sweep over every class with varied data
    for (int n = 0; n < 4000; n++) begin
      apply(14'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom), "sweep");
    end
    finish_run();
  end
endmodule